// File: doc/BRIEF.md
# PIO Timing Clock-Count Calculator

This block converts the nanosecond timing of a disk programmed-I/O transfer mode into bus clock counts. A caller presents the setup time, the active (strobe) time and the full cycle time in nanoseconds. It also presents the bus frequency in MHz and a silicon revision code, and raises `start` for one cycle. The block first derives the bus clock period from the frequency. It then runs four ceiling divisions through a single shared shift-subtract divider. Finally it applies the minimum, rebalancing and cap rules that make the counts fit the nibble-wide timing registers of the disk controller.

A zero frequency input selects a default bus speed, which depends on whether the controller sits on a local bus or on PCI. The finished counts appear together with a one-cycle `done` pulse. They are held until the next calculation completes. A `start` pulse arriving while a calculation is running has no effect.

Top module: `pio_clock_calc`

## Requirements
- R1: The clock period is floor(1000 / F) ns, where F is `busMhz`; when `busMhz` is 0, F is 50 if `localBus` is 1 and 33 if `localBus` is 0.
- R2: `setupCnt` is the ceiling of `setupNs` divided by the period, with no minimum and no cap.
- R3: The active count starts as the ceiling of `activeNs` divided by the period and is raised to 2 when it is below 2.
- R4: The recovery time is `cycleNs` - `setupNs` - `activeNs`, taken as 0 when negative. The recovery count is the larger of two values. One is the ceiling of the recovery time divided by the period. The other is ceil(`cycleNs`/period) minus the setup count and the raised active count, taken as 0 when negative. The result is then raised to at least 2.
- R5: When the recovery count exceeds 17, the excess is added to the active count and recovery becomes 17. After that, `activeCnt` is capped at 16.
- R6: When `revCode` is greater than 1, the recovery count is reduced by 1. After that, `recoveryCnt` is capped at 16.
- R7: `done` is high for exactly one cycle per calculation, and the three count outputs change only in the cycle where `done` is high.
- R8: `busy` is high from the cycle after an accepted `start` until `done` rises. A `start` while `busy` is high is ignored, and the result reflects the inputs of the accepted `start`.
- R9: After reset, `busy`, `done` and all three count outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation with the present inputs |
| setupNs | input | TIME_W | Address setup time in ns |
| activeNs | input | TIME_W | Strobe active time in ns |
| cycleNs | input | TIME_W | Whole transfer cycle time in ns |
| busMhz | input | MHZ_W | Bus frequency in MHz, 0 selects the default |
| localBus | input | 1 | Picks the local-bus default (1) or the PCI default (0) |
| revCode | input | 2 | Silicon revision code |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when new counts are presented |
| setupCnt | output | SET_W | Setup clock count |
| activeCnt | output | 5 | Active clock count, 2 to 16 |
| recoveryCnt | output | 5 | Recovery clock count, 1 to 16 |

## Verification
The rebalancing path is the hardest state to reach from the ports. Recovery only passes 17 clocks when the bus is fast, the cycle is long and the active time is short. In that case the excess must move into the active count, and the 16 cap must then bite. Plain random stimulus seldom lines these up, so directed cases set a 100 MHz bus with a 600 ns cycle. They also saturate the negative recovery difference by giving a cycle shorter than setup plus active. A mid-calculation `start` carrying different operands shows that the latched operands are kept.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;
  localparam int STEP_W    = 3;
  localparam int LAST_STEP = 4;
  localparam int CNT_W     = 5;
  localparam int ACT_MIN   = 2;
  localparam int REC_MIN   = 2;
  localparam int REC_LIMIT = 17;
  localparam int CNT_MAX   = 16;

  typedef struct packed {
    logic load;
    logic divGo;
    logic capture;
    logic finish;
  } ctl_strobe_t;
endpackage

// File: rtl/pio_calc_div.sv
module pio_calc_div #(
  parameter int W = 11,
  localparam int BC_W = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  logic [W-1:0]    quoR, remR, denR;
  logic [BC_W-1:0] bitsLeft;
  logic            running;
  logic [W:0]      shifted;
  logic [W-1:0]    diffW;
  logic            fits;

  assign shifted = {remR, quoR[W-1]};
  assign fits    = shifted >= {1'b0, denR};
  assign diffW   = shifted[W-1:0] - denR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoR     <= '0;
      remR     <= '0;
      denR     <= '0;
      bitsLeft <= '0;
      running  <= 1'b0;
      done     <= 1'b0;
    end else if (go) begin
      quoR     <= num;
      remR     <= '0;
      denR     <= den;
      bitsLeft <= BC_W'(W);
      running  <= 1'b1;
      done     <= 1'b0;
    end else if (running) begin
      quoR     <= {quoR[W-2:0], fits};
      remR     <= fits ? diffW : shifted[W-1:0];
      bitsLeft <= bitsLeft - 1'b1;
      if (bitsLeft == BC_W'(1)) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quot = quoR;
  assign rem  = remR;
endmodule

// File: rtl/pio_calc_ctrl.sv
module pio_calc_ctrl
  import pio_calc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              divDone,
  output ctl_strobe_t       strobes,
  output logic [STEP_W-1:0] step,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_KICK, S_WAIT, S_FIN} state_t;
  state_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (start) begin
        strobes.load = 1'b1;
        stateNext    = S_KICK;
      end
      S_KICK: begin
        strobes.divGo = 1'b1;
        stateNext     = S_WAIT;
      end
      S_WAIT: if (divDone) begin
        strobes.capture = 1'b1;
        stateNext       = (step == STEP_W'(LAST_STEP)) ? S_FIN : S_KICK;
      end
      default: begin
        strobes.finish = 1'b1;
        stateNext      = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.finish;
      if (strobes.load)
        step <= '0;
      else if (strobes.capture && step != STEP_W'(LAST_STEP))
        step <= step + 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/pio_calc_dp.sv
module pio_calc_dp
  import pio_calc_pkg::*;
#(
  parameter int TIME_W        = 11,
  parameter int MHZ_W         = 8,
  parameter int DEF_LOCAL_MHZ = 50,
  parameter int DEF_PCI_MHZ   = 33,
  localparam int DW    = (TIME_W > 10) ? TIME_W : 10,
  localparam int SET_W = DW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobes,
  input  logic [STEP_W-1:0] step,
  input  logic [TIME_W-1:0] setupNs,
  input  logic [TIME_W-1:0] activeNs,
  input  logic [TIME_W-1:0] cycleNs,
  input  logic [MHZ_W-1:0]  busMhz,
  input  logic              localBus,
  input  logic [1:0]        revCode,
  output logic              divDone,
  output logic [SET_W-1:0]  setupCnt,
  output logic [CNT_W-1:0]  activeCnt,
  output logic [CNT_W-1:0]  recoveryCnt
);
  localparam int CW = DW + 3;
  localparam logic [DW-1:0] NS_PER_US = DW'(1000);

  logic [TIME_W-1:0] setNs, actNs, cycNs, recNs;
  logic [TIME_W:0]   saSum;
  logic [MHZ_W-1:0]  mhzIn, mhzEff;
  logic [1:0]        rev;
  logic [DW-1:0]     periodReg, num, den, quot, rem;
  logic [SET_W-1:0]  ceilVal, setC, actC, recC, cycC;
  logic [CW-1:0]     aFin, rFin, sumSA, recAlt;

  assign mhzIn = (busMhz == '0) ? (localBus ? MHZ_W'(DEF_LOCAL_MHZ) : MHZ_W'(DEF_PCI_MHZ))
                                : busMhz;
  assign saSum = {1'b0, setNs} + {1'b0, actNs};
  assign recNs = ({1'b0, cycNs} > saSum) ? TIME_W'({1'b0, cycNs} - saSum) : '0;

  always_comb begin
    case (step)
      STEP_W'(0): num = NS_PER_US;
      STEP_W'(1): num = DW'(setNs);
      STEP_W'(2): num = DW'(actNs);
      STEP_W'(3): num = DW'(recNs);
      default:    num = DW'(cycNs);
    endcase
    den = (step == '0) ? DW'(mhzEff) : periodReg;
  end

  pio_calc_div #(.W(DW)) u_div (
    .clk  (clk),
    .rstN (rstN),
    .go   (strobes.divGo),
    .num  (num),
    .den  (den),
    .done (divDone),
    .quot (quot),
    .rem  (rem)
  );

  assign ceilVal = {1'b0, quot} + SET_W'(rem != '0);

  always_comb begin
    aFin   = (CW'(actC) < CW'(ACT_MIN)) ? CW'(ACT_MIN) : CW'(actC);
    sumSA  = CW'(setC) + aFin;
    recAlt = (CW'(cycC) > sumSA) ? CW'(cycC) - sumSA : '0;
    rFin   = (CW'(recC) > recAlt) ? CW'(recC) : recAlt;
    if (rFin < CW'(REC_MIN)) rFin = CW'(REC_MIN);
    if (rFin > CW'(REC_LIMIT)) begin
      aFin = aFin + rFin - CW'(REC_LIMIT);
      rFin = CW'(REC_LIMIT);
    end
    if (aFin > CW'(CNT_MAX)) aFin = CW'(CNT_MAX);
    if (rev > 2'd1) rFin = rFin - CW'(1);
    if (rFin > CW'(CNT_MAX)) rFin = CW'(CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setNs       <= '0;
      actNs       <= '0;
      cycNs       <= '0;
      mhzEff      <= '0;
      rev         <= '0;
      periodReg   <= '0;
      setC        <= '0;
      actC        <= '0;
      recC        <= '0;
      cycC        <= '0;
      setupCnt    <= '0;
      activeCnt   <= '0;
      recoveryCnt <= '0;
    end else begin
      if (strobes.load) begin
        setNs  <= setupNs;
        actNs  <= activeNs;
        cycNs  <= cycleNs;
        mhzEff <= mhzIn;
        rev    <= revCode;
      end
      if (strobes.capture) begin
        case (step)
          STEP_W'(0): periodReg <= (quot == '0) ? DW'(1) : quot;
          STEP_W'(1): setC <= ceilVal;
          STEP_W'(2): actC <= ceilVal;
          STEP_W'(3): recC <= ceilVal;
          default:    cycC <= ceilVal;
        endcase
      end
      if (strobes.finish) begin
        setupCnt    <= setC;
        activeCnt   <= aFin[CNT_W-1:0];
        recoveryCnt <= rFin[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pio_clock_calc.sv
module pio_clock_calc
  import pio_calc_pkg::*;
#(
  parameter int TIME_W        = 11,
  parameter int MHZ_W         = 8,
  parameter int DEF_LOCAL_MHZ = 50,
  parameter int DEF_PCI_MHZ   = 33,
  localparam int DW    = (TIME_W > 10) ? TIME_W : 10,
  localparam int SET_W = DW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TIME_W-1:0] setupNs,
  input  logic [TIME_W-1:0] activeNs,
  input  logic [TIME_W-1:0] cycleNs,
  input  logic [MHZ_W-1:0]  busMhz,
  input  logic              localBus,
  input  logic [1:0]        revCode,
  output logic              busy,
  output logic              done,
  output logic [SET_W-1:0]  setupCnt,
  output logic [4:0]        activeCnt,
  output logic [4:0]        recoveryCnt
);
  ctl_strobe_t       strobes;
  logic [STEP_W-1:0] step;
  logic              divDone;

  pio_calc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .divDone (divDone),
    .strobes (strobes),
    .step    (step),
    .busy    (busy),
    .done    (done)
  );

  pio_calc_dp #(
    .TIME_W        (TIME_W),
    .MHZ_W         (MHZ_W),
    .DEF_LOCAL_MHZ (DEF_LOCAL_MHZ),
    .DEF_PCI_MHZ   (DEF_PCI_MHZ)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .step        (step),
    .setupNs     (setupNs),
    .activeNs    (activeNs),
    .cycleNs     (cycleNs),
    .busMhz      (busMhz),
    .localBus    (localBus),
    .revCode     (revCode),
    .divDone     (divDone),
    .setupCnt    (setupCnt),
    .activeCnt   (activeCnt),
    .recoveryCnt (recoveryCnt)
  );
endmodule

// File: rtl/pio_calc_chk.sv
module pio_calc_chk #(
  parameter int SET_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [SET_W-1:0] setupCnt,
  input logic [4:0]       activeCnt,
  input logic [4:0]       recoveryCnt
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_hold_outputs_r7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(setupCnt) && $stable(activeCnt) && $stable(recoveryCnt)));

  p_active_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (activeCnt >= 5'd2));

  p_active_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (activeCnt <= 5'd16));

  p_recovery_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (recoveryCnt >= 5'd1 && recoveryCnt <= 5'd16));

  p_busy_on_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_busy_until_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));
endmodule

bind pio_clock_calc pio_calc_chk #(.SET_W(SET_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .setupCnt    (setupCnt),
  .activeCnt   (activeCnt),
  .recoveryCnt (recoveryCnt)
);

// File: tb/tb_pio_clock_calc.sv
module tb_pio_clock_calc;
  localparam int TIME_W = 11;
  localparam int MHZ_W  = 8;
  localparam int SET_W  = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [TIME_W-1:0] setupNs = '0, activeNs = '0, cycleNs = '0;
  logic [MHZ_W-1:0]  busMhz = '0;
  logic              localBus = 1'b0;
  logic [1:0]        revCode = '0;
  logic              busy, done;
  logic [SET_W-1:0]  setupCnt;
  logic [4:0]        activeCnt, recoveryCnt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pio_clock_calc dut (
    .clk(clk), .rstN(rstN), .start(start),
    .setupNs(setupNs), .activeNs(activeNs), .cycleNs(cycleNs),
    .busMhz(busMhz), .localBus(localBus), .revCode(revCode),
    .busy(busy), .done(done), .setupCnt(setupCnt),
    .activeCnt(activeCnt), .recoveryCnt(recoveryCnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  task automatic model(input int s, input int a, input int c, input int m,
                       input int lb, input int rv,
                       output int es, output int ea, output int er);
    int f, p, rn, sc, ac, rc, cc, alt;
    f  = (m == 0) ? (lb != 0 ? 50 : 33) : m;          // R1
    p  = 1000 / f;
    if (p == 0) p = 1;
    rn = (c > s + a) ? c - s - a : 0;                  // R4
    sc = cdiv(s, p);                                   // R2
    ac = cdiv(a, p);
    rc = cdiv(rn, p);
    cc = cdiv(c, p);
    if (ac < 2) ac = 2;                                // R3
    alt = (cc > sc + ac) ? cc - sc - ac : 0;
    if (alt > rc) rc = alt;
    if (rc < 2) rc = 2;
    if (rc > 17) begin ac = ac + rc - 17; rc = 17; end // R5
    if (ac > 16) ac = 16;
    if (rv > 1) rc = rc - 1;                           // R6
    if (rc > 16) rc = 16;
    es = sc; ea = ac; er = rc;
  endtask

  task automatic runCase(input int s, input int a, input int c, input int m,
                         input int lb, input int rv, input string tag, input bit poke);
    int es, ea, er, n;
    logic [SET_W-1:0] holdS;
    model(s, a, c, m, lb, rv, es, ea, er);
    @(negedge clk);
    setupNs = TIME_W'(s); activeNs = TIME_W'(a); cycleNs = TIME_W'(c);
    busMhz = MHZ_W'(m); localBus = lb[0]; revCode = rv[1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R8 busy after start"}, int'(busy), 1);
    if (poke) begin
      @(negedge clk);
      setupNs = TIME_W'(1500); activeNs = TIME_W'(7); cycleNs = TIME_W'(9);
      busMhz = MHZ_W'(250); revCode = 2'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, {tag, " R7 done seen"}, int'(done), 1);
    chk(busy == 1'b0, {tag, " R8 idle at done"}, int'(busy), 0);
    chk(int'(setupCnt) == es, {tag, " R2 setup count"}, int'(setupCnt), es);
    chk(int'(activeCnt) == ea, {tag, " R3 R5 active count"}, int'(activeCnt), ea);
    chk(int'(recoveryCnt) == er, {tag, " R4 R6 recovery count"}, int'(recoveryCnt), er);
    holdS = setupCnt;
    @(negedge clk);
    chk(done == 1'b0, {tag, " R7 done single cycle"}, int'(done), 0);
    @(negedge clk);
    chk(setupCnt == holdS && int'(activeCnt) == ea && int'(recoveryCnt) == er,
        {tag, " R7 outputs held"}, int'(setupCnt), int'(holdS));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9 control idle in reset", int'(busy) + int'(done), 0);
    chk(setupCnt == '0 && activeCnt == '0 && recoveryCnt == '0, "R9 counts zero in reset",
        int'(setupCnt) + int'(activeCnt) + int'(recoveryCnt), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9 idle after reset", int'(busy) + int'(done), 0);

    runCase(70, 165, 600, 0, 1, 1, "R1 local default", 1'b0);
    runCase(70, 165, 600, 0, 0, 1, "R1 pci default", 1'b0);
    runCase(2000, 10, 2047, 255, 0, 0, "R2 large setup", 1'b0);
    runCase(0, 0, 0, 33, 0, 0, "R3 all zero", 1'b0);
    runCase(25, 1, 90, 50, 0, 1, "R3 short active", 1'b0);
    runCase(300, 300, 100, 66, 1, 0, "R4 negative recovery", 1'b0);
    runCase(70, 165, 600, 100, 0, 1, "R5 rebalance", 1'b0);
    runCase(30, 50, 600, 200, 0, 1, "R5 active cap", 1'b0);
    runCase(70, 165, 600, 100, 0, 2, "R6 rev two", 1'b0);
    runCase(0, 0, 0, 33, 0, 3, "R6 rev three low", 1'b0);
    runCase(25, 70, 120, 33, 0, 2, "R8 ignored start", 1'b1);

    for (int i = 0; i < 300; i++) begin
      int s, a, c, m;
      s = int'($urandom_range(0, 250));
      a = int'($urandom_range(0, 500));
      c = int'($urandom_range(0, 900));
      m = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(1, 255));
      runCase(s, a, c, m, int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
              "random R1 R2 R3 R4 R5 R6", 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule